// File: doc/BRIEF.md
# Four-Word Result Stack Sequencer

This block sits between a serial bus engine and a successive-approximation converter core. A valid command from the bus engine opens a conversion sequence. The block then powers the core and starts conversions back to back, one after another. Each finished 12-bit result is pushed onto a four-entry last-in first-out stack. Conversions continue until the read-address arrives or until a STOP or an invalid command ends the sequence.

Once the read-address has arrived, the core is powered down and the bus engine pulls words one at a time. The most recent result comes out first. In single-result mode, which is used for high-speed bus operation, only one conversion is made per sequence. A ready output tells the bus engine that at least one word is waiting, so it can stretch the clock or hold off.

The converter core is seen only through a start pulse, a power enable, and a done pulse that carries the result.

Top module: `result_stack_seq`

## Requirements
- R1: After reset, core_pwr_o, core_start_o, ready_o, word_valid_o and underflow_o are low, count_o is 0 and word_o is 0.
- R2: A cmd_valid_i pulse while idle or in the read phase does three things: it clears the stack, it raises core_pwr_o on the next edge, and it starts conversion. While converting, core_start_o pulses whenever no conversion is in flight. Every core_done_i result seen while converting is stored.
- R3: The stack holds at most four words. When a fifth or later result arrives, it replaces the most recently stored entry, and count_o stays at 4.
- R4: A rd_addr_i pulse while converting drops core_pwr_o on the next edge and enters the read phase. No further core_start_o pulses are issued.
- R5: In the read phase, a pop_i pulse removes the most recent word. The word appears on word_o one cycle later, together with a one-cycle word_valid_o pulse and underflow_o low.
- R6: A pop_i pulse on an empty stack in the read phase gives word_o = 0 and underflow_o = 1, with word_valid_o pulsed. This is the result of any read beyond the stored words.
- R7: A cmd_bad_i pulse, which marks an invalid command or a NACK after a repeated command, empties the stack and leaves core_pwr_o low from the next edge on. It takes priority over all other requests.
- R8: Without a read-address, core_pwr_o stays high until stop_i. A stop_i pulse drops core_pwr_o on the next edge, and the stored words are kept.
- R9: With hs_mode_i high, a sequence issues exactly one core_start_o pulse and stores one word. The first pop returns that word and a second pop underflows.
- R10: ready_o is high exactly when count_o is non-zero.
- R11: A pop_i pulse outside the read phase has no effect: there is no word_valid_o pulse and count_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Valid conversion command received |
| cmd_bad_i | input | 1 | Invalid command or NACK after a repeated command |
| rd_addr_i | input | 1 | Read-address byte received |
| stop_i | input | 1 | STOP condition seen |
| hs_mode_i | input | 1 | Single-result (high-speed) mode |
| pop_i | input | 1 | Read request for one word |
| core_done_i | input | 1 | Converter result valid pulse |
| core_data_i | input | 12 | Converter result |
| core_start_o | output | 1 | Start one conversion |
| core_pwr_o | output | 1 | Core power and conversion clock enable |
| word_o | output | 12 | Popped word |
| word_valid_o | output | 1 | One-cycle pulse when word_o is updated |
| underflow_o | output | 1 | Last pop found the stack empty |
| ready_o | output | 1 | At least one word stored |
| count_o | output | 3 | Words stored |

## Verification
The bench uses the default parameter values: a depth of four and a 12-bit data width. With these values, the four-entry limit is reached after only a few conversions, so the overwrite of the newest entry and the count saturating at four are both exercised. A converter model with a three-cycle latency makes every read-address arrival race a conversion that may be in flight, and its results are logged to build the expected stack. Single-result mode, STOP without a read, and clearing by a bad command are each run as their own sequence.

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_READ = 2'd2
  } phase_e;
endpackage

// File: rtl/rss_conv_ctrl.sv
module rss_conv_ctrl
  import rss_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cmd_valid_i,
  input  logic   cmd_bad_i,
  input  logic   rd_addr_i,
  input  logic   stop_i,
  input  logic   hs_mode_i,
  input  logic   core_done_i,
  output phase_e phase_o,
  output logic   core_start_o,
  output logic   core_pwr_o,
  output logic   clear_o,
  output logic   push_o
);
  phase_e phase_q, phase_d;
  logic   busy_q, busy_d;
  logic   hs_taken_q, hs_taken_d;
  logic   go_conv;

  // priority: bad command > stop > read-address > command
  always_comb begin
    phase_d = phase_q;
    go_conv = 1'b0;
    if (cmd_bad_i) begin
      phase_d = PH_IDLE;
    end else if (stop_i) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: go_conv = cmd_valid_i;
        PH_CONV: if (rd_addr_i) phase_d = PH_READ;
        PH_READ: go_conv = cmd_valid_i;
        default: phase_d = PH_IDLE;
      endcase
      if (go_conv) phase_d = PH_CONV;
    end
  end

  assign core_pwr_o   = (phase_q == PH_CONV);
  assign core_start_o = core_pwr_o && !busy_q && !(hs_mode_i && hs_taken_q);
  assign push_o       = core_pwr_o && busy_q && core_done_i;
  assign clear_o      = cmd_bad_i || go_conv;
  assign phase_o      = phase_q;

  always_comb begin
    busy_d = busy_q;
    if (phase_d != PH_CONV || go_conv) busy_d = 1'b0;
    else if (core_start_o)             busy_d = 1'b1;
    else if (core_done_i)              busy_d = 1'b0;
  end

  always_comb begin
    hs_taken_d = hs_taken_q;
    if (go_conv)                 hs_taken_d = 1'b0;
    else if (push_o && hs_mode_i) hs_taken_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      busy_q     <= 1'b0;
      hs_taken_q <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      busy_q     <= busy_d;
      hs_taken_q <= hs_taken_d;
    end
  end
endmodule

// File: rtl/rss_lifo.sv
module rss_lifo #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              underflow_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  wr_idx, top_idx;

  assign wr_idx  = PTR_W'(cnt_q);
  assign top_idx = PTR_W'(cnt_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      cnt_q       <= '0;
      rd_data_o   <= '0;
      rd_valid_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      if (clear_i) begin
        cnt_q <= '0;
      end else if (push_i) begin
        // when full, the newest result replaces the top entry
        if (cnt_q < FULL) begin
          mem_q[wr_idx] <= push_data_i;
          cnt_q         <= cnt_q + 1'b1;
        end else begin
          mem_q[LAST] <= push_data_i;
        end
      end else if (pop_i) begin
        rd_valid_o <= 1'b1;
        if (cnt_q != '0) begin
          rd_data_o   <= mem_q[top_idx];
          underflow_o <= 1'b0;
          cnt_q       <= cnt_q - 1'b1;
        end else begin
          rd_data_o   <= '0;
          underflow_o <= 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/result_stack_seq.sv
module result_stack_seq
  import rss_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_bad_i,
  input  logic              rd_addr_i,
  input  logic              stop_i,
  input  logic              hs_mode_i,
  input  logic              pop_i,
  input  logic              core_done_i,
  input  logic [DATA_W-1:0] core_data_i,
  output logic              core_start_o,
  output logic              core_pwr_o,
  output logic [DATA_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              underflow_o,
  output logic              ready_o,
  output logic [CNT_W-1:0]  count_o
);
  phase_e phase;
  logic   clear, push, rd_phase;

  rss_conv_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_bad_i   (cmd_bad_i),
    .rd_addr_i   (rd_addr_i),
    .stop_i      (stop_i),
    .hs_mode_i   (hs_mode_i),
    .core_done_i (core_done_i),
    .phase_o     (phase),
    .core_start_o(core_start_o),
    .core_pwr_o  (core_pwr_o),
    .clear_o     (clear),
    .push_o      (push)
  );

  assign rd_phase = (phase == PH_READ);

  rss_lifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_lifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .push_i     (push),
    .push_data_i(core_data_i),
    .pop_i      (pop_i && rd_phase),
    .rd_data_o  (word_o),
    .rd_valid_o (word_valid_o),
    .underflow_o(underflow_o),
    .cnt_o      (count_o)
  );

  assign ready_o = (count_o != '0);
endmodule

// File: rtl/result_stack_seq_chk.sv
module result_stack_seq_chk #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_bad_i,
  input logic              rd_addr_i,
  input logic              stop_i,
  input logic              pop_i,
  input logic              core_done_i,
  input logic              core_start_o,
  input logic              core_pwr_o,
  input logic [DATA_W-1:0] word_o,
  input logic              word_valid_o,
  input logic              underflow_o,
  input logic              ready_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              rd_phase
);
  AST_START_NEEDS_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |-> core_pwr_o); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH)); // R3
  AST_RDADDR_PWR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_pwr_o && rd_addr_i) |=> !core_pwr_o && !core_start_o); // R4
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> word_o == '0); // R6
  AST_BAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_bad_i |=> (count_o == '0) && !core_pwr_o); // R7
  AST_STOP_PWR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !core_pwr_o); // R8
  AST_READY_AFTER_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_pwr_o && core_done_i && !cmd_bad_i) |=> ready_o); // R10
  AST_POP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !rd_phase) |=> !word_valid_o); // R11
endmodule

bind result_stack_seq result_stack_seq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_bad_i   (cmd_bad_i),
  .rd_addr_i   (rd_addr_i),
  .stop_i      (stop_i),
  .pop_i       (pop_i),
  .core_done_i (core_done_i),
  .core_start_o(core_start_o),
  .core_pwr_o  (core_pwr_o),
  .word_o      (word_o),
  .word_valid_o(word_valid_o),
  .underflow_o (underflow_o),
  .ready_o     (ready_o),
  .count_o     (count_o),
  .rd_phase    (rd_phase)
);

// File: tb/result_stack_seq_test.sv
`timescale 1ns/1ps
module result_stack_seq_test;
  localparam int DW  = 12;
  localparam int DEP = 4;
  localparam int LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_bad = 0, rd_addr = 0, stop = 0, hs = 0, pop = 0;
  logic core_done = 0;
  logic [DW-1:0] core_data = '0;
  logic core_start, core_pwr, word_valid, underflow, ready;
  logic [DW-1:0] word;
  logic [2:0] count;

  int checks = 0, errors = 0, cyc = 0, lat = 0, starts = 0;
  logic [DW-1:0] next_val = 12'h100;
  logic [DW-1:0] conv_log[$];
  logic [DW-1:0] mstack[$];
  logic [DW-1:0] exp_w[$];
  logic          exp_u[$];

  always #2.5 clk = ~clk;

  result_stack_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_bad_i(cmd_bad),
    .rd_addr_i(rd_addr), .stop_i(stop), .hs_mode_i(hs), .pop_i(pop),
    .core_done_i(core_done), .core_data_i(core_data), .core_start_o(core_start),
    .core_pwr_o(core_pwr), .word_o(word), .word_valid_o(word_valid),
    .underflow_o(underflow), .ready_o(ready), .count_o(count)
  );

  // converter core model, acts just after each rising edge
  always @(posedge clk) begin
    #1;
    core_done = 1'b0;
    if (!core_pwr) lat = 0;
    else if (lat > 0) begin
      lat = lat - 1;
      if (lat == 0) begin
        core_done = 1'b1;
        core_data = next_val;
        conv_log.push_back(next_val);
        next_val = next_val + 12'h011;
      end
    end else if (core_start) begin
      lat = LAT;
      starts++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      checks++;
      if (exp_w.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected word actual %0h expected none", word);
      end else begin
        logic [DW-1:0] ew;
        logic eu;
        ew = exp_w.pop_front();
        eu = exp_u.pop_front();
        if (word !== ew || underflow !== eu) begin
          errors++;
          $display("FAIL R5/R6 word actual %0h/%0b expected %0h/%0b", word, underflow, ew, eu);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog R2 actual hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cmd();
    conv_log.delete();
    starts = 0;
    cmd_valid = 1; tick(1); cmd_valid = 0;
  endtask

  task automatic do_rdaddr();
    rd_addr = 1; tick(1); rd_addr = 0;
    // model stack from logged results (overwrite top when full)
    mstack.delete();
    foreach (conv_log[i]) begin
      if (mstack.size() < DEP) mstack.push_back(conv_log[i]);
      else mstack[DEP-1] = conv_log[i];
    end
  endtask

  task automatic do_pop();
    if (mstack.size() > 0) begin
      exp_w.push_back(mstack.pop_back());
      exp_u.push_back(1'b0);
    end else begin
      exp_w.push_back('0);
      exp_u.push_back(1'b1);
    end
    pop = 1; tick(1); pop = 0;
  endtask

  task automatic wait_count(input int n);
    for (int k = 0; k < 200 && count < 3'(n); k++) tick(1);
  endtask

  initial begin
    tick(3);
    // R1 reset state
    chk(!core_pwr && !core_start && !ready && !word_valid && !underflow, "R1 ctl", 0, 0);
    chk(count == 0 && word == 0, "R1 data", int'(count), 0);
    rst_n = 1;
    tick(2);

    // R2 R4 R5 R10: short sequence
    do_cmd();
    chk(core_pwr == 1, "R2 pwr on", core_pwr, 1);
    wait_count(2);
    chk(ready == 1, "R10 ready", ready, 1);
    do_rdaddr();
    chk(core_pwr == 0 && core_start == 0, "R4 pwr off", core_pwr, 0);
    tick(10);
    chk(int'(count) == conv_log.size(), "R4 no more results", int'(count), conv_log.size());
    for (int i = 0; i < 3; i++) do_pop(); // R5, R6 on last
    tick(2);
    chk(ready == 0 && count == 0, "R10 ready low", ready, 0);

    // R3 overflow
    do_cmd();
    for (int k = 0; k < 300 && conv_log.size() < 7; k++) tick(1);
    chk(count == 3'd4, "R3 saturate", int'(count), 4);
    do_rdaddr();
    for (int i = 0; i < 5; i++) do_pop(); // fifth pop: R6
    tick(2);

    // R8 stop without read, then R11 pop ignored
    do_cmd();
    tick(30);
    chk(core_pwr == 1, "R8 pwr held", core_pwr, 1);
    stop = 1; tick(1); stop = 0;
    chk(core_pwr == 0, "R8 stop off", core_pwr, 0);
    tick(8);
    begin
      logic [2:0] c0;
      c0 = count;
      chk(c0 != 0, "R8 words kept", int'(c0), 1);
      pop = 1; tick(1); pop = 0;
      tick(2);
      chk(count == c0, "R11 pop ignored", int'(count), int'(c0));
    end

    // R7 bad command clears
    do_cmd();
    wait_count(2);
    cmd_bad = 1; tick(1); cmd_bad = 0;
    chk(count == 0 && !core_pwr, "R7 clear", int'(count), 0);
    tick(10);
    chk(count == 0 && !core_start && !ready, "R7 stays off", int'(count), 0);

    // R9 single-result mode
    hs = 1;
    do_cmd();
    tick(40);
    chk(starts == 1, "R9 one start", starts, 1);
    chk(count == 1, "R9 one word", int'(count), 1);
    do_rdaddr();
    do_pop();
    do_pop();
    tick(3);
    hs = 0;

    chk(exp_w.size() == 0, "R5 scoreboard drained", exp_w.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule